// File: doc/BRIEF.md
# Processor Status Word Unit

This unit keeps the eight-bit status word of a small 8-bit RISC core. Each cycle it can take fresh arithmetic flags from the ALU together with a per-flag write mask from the decoder, move a single bit between a register operand and the transfer flag T, and react to interrupt-control events: interrupt entry, return-from-interrupt, and explicit enable-set and enable-clear. It presents the whole word, the global interrupt enable and the transfer flag as separate outputs. It also gates the core's pending interrupt requests, so that no request reaches the vectoring logic while the global enable is off.

The sign flag is never loaded from the ALU. It is recomputed as the exclusive-or of the negative and overflow flags whenever either of those two is written. Bit-load is purely combinational: the operand comes back on a writeback output with one selected bit replaced by the current T. The register file lies outside the unit.

Top module: `sreg_unit`

## Requirements
- R1: After a synchronous active-high reset every bit of the status word reads 0, and `gie_o`, `tflag_o` and `irq_take_o` are 0.
- R2: The word layout from bit 7 down to bit 0 is I, T, H, S, V, N, Z, C. For each of H (bit 5), V (bit 3), N (bit 2), Z (bit 1) and C (bit 0), a 1 at the same position of `upd_mask_i` loads the matching bit of `alu_flags_i` at the next clock edge. A 0 at that position leaves the flag unchanged.
- R3: Mask and ALU-flag bits 7 (I), 6 (T) and 4 (S) have no effect on the status word.
- R4: Whenever N or V is written, S becomes N XOR V of the new values, so S equals N XOR V at all times.
- R5: When `bst_i` is high, T takes bit `bit_sel_i` of `opnd_i` at the next edge. Otherwise T holds its value, and ALU updates never change T.
- R6: `bld_data_o` equals `opnd_i` with bit `bit_sel_i` replaced by the current T, combinationally.
- R7: When `irq_entry_i` is high, I is 0 after the next edge.
- R8: When `reti_i` is high and neither `irq_entry_i` nor `cli_i` is high, I is 1 after the next edge.
- R9: `sei_i` sets I and `cli_i` clears I. If both are high in the same cycle, the clear wins.
- R10: If interrupt entry coincides with `sei_i` or `reti_i`, entry wins and I becomes 0.
- R11: `irq_take_o` is 1 only when I is 1 and at least one source has both its request bit and its enable bit high. While I is 0 it stays 0, whatever the per-source enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_flags_i | input | 8 | ALU flag results, aligned to the status layout |
| upd_mask_i | input | 8 | Per-flag write mask, aligned to the status layout |
| bst_i | input | 1 | Bit-store: copy a selected operand bit into T |
| bld_i | input | 1 | Bit-load strobe, marks `bld_data_o` as valid for writeback |
| bit_sel_i | input | 3 | Bit position used by bit-store and bit-load |
| opnd_i | input | 8 | Register-file operand for bit-copy |
| bld_data_o | output | 8 | Operand with the selected bit replaced by T |
| irq_entry_i | input | 1 | An interrupt is being taken |
| reti_i | input | 1 | Return-from-interrupt |
| sei_i | input | 1 | Set global interrupt enable |
| cli_i | input | 1 | Clear global interrupt enable |
| irq_req_i | input | 4 | Per-source interrupt requests |
| irq_en_i | input | 4 | Per-source interrupt enables |
| irq_take_o | output | 1 | A gated request is pending |
| sreg_o | output | 8 | Current status word |
| gie_o | output | 1 | Global interrupt enable (I) |
| tflag_o | output | 1 | Transfer flag (T) |

## Verification
Every flag is a register that drives `sreg_o` directly, so a wrong internal state shows up on the ports one cycle after the update that caused it. A masked flag that was written by mistake, or an S that was not recomputed, differs from the expected word at the very next sample. A stuck or wrongly prioritized I bit shows in `gie_o` within one cycle. It shows in the same cycle on `irq_take_o`, because that output is combinational on the registered enable. A bad T value first appears on `tflag_o`, and also in `bld_data_o` at the selected position as soon as a bit-load is presented.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int SW = 8;

    localparam int B_I = 7;
    localparam int B_T = 6;
    localparam int B_H = 5;
    localparam int B_S = 4;
    localparam int B_V = 3;
    localparam int B_N = 2;
    localparam int B_Z = 1;
    localparam int B_C = 0;

    // Flags that only the ALU path may write
    localparam logic [SW-1:0] ALU_OWNED = (SW'(1) << B_H) | (SW'(1) << B_V) |
                                          (SW'(1) << B_N) | (SW'(1) << B_Z) |
                                          (SW'(1) << B_C);

    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

    typedef enum logic [1:0] {
        GIE_HOLD  = 2'd0,
        GIE_ENTRY = 2'd1,
        GIE_CLEAR = 2'd2,
        GIE_SET   = 2'd3
    } gie_act_e;

    function automatic logic sign_of(input logic n, input logic v);
        return n ^ v;
    endfunction

    function automatic gie_act_e gie_decide(input logic entry, input logic cli,
                                            input logic sei, input logic reti);
        if (entry)           return GIE_ENTRY;
        else if (cli)        return GIE_CLEAR;
        else if (sei | reti) return GIE_SET;
        else                 return GIE_HOLD;
    endfunction

endpackage

// File: rtl/sreg_flag_merge.sv
module sreg_flag_merge
    import sreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] alu_flags_i,
    input  logic [SW-1:0] upd_mask_i,
    output logic          h_o,
    output logic          s_o,
    output logic          v_o,
    output logic          n_o,
    output logic          z_o,
    output logic          c_o
);

    logic [SW-1:0] eff_mask;
    logic [SW-1:0] cur_bits;
    logic [SW-1:0] nxt_bits;
    logic          sign_upd;
    logic          h_q, s_q, v_q, n_q, z_q, c_q;
    logic          s_nxt;

    assign eff_mask = upd_mask_i & ALU_OWNED;

    always_comb begin
        cur_bits      = '0;
        cur_bits[B_H] = h_q;
        cur_bits[B_V] = v_q;
        cur_bits[B_N] = n_q;
        cur_bits[B_Z] = z_q;
        cur_bits[B_C] = c_q;
    end

    for (genvar k = 0; k < SW; k++) begin : g_merge
        if (ALU_OWNED[k]) begin : g_owned
            assign nxt_bits[k] = eff_mask[k] ? alu_flags_i[k] : cur_bits[k];
        end else begin : g_other
            assign nxt_bits[k] = 1'b0;
        end
    end

    assign sign_upd = eff_mask[B_N] | eff_mask[B_V];

    always_comb begin
        if (sign_upd) s_nxt = sign_of(nxt_bits[B_N], nxt_bits[B_V]);
        else          s_nxt = s_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= 1'b0;
            s_q <= 1'b0;
            v_q <= 1'b0;
            n_q <= 1'b0;
            z_q <= 1'b0;
            c_q <= 1'b0;
        end else begin
            h_q <= nxt_bits[B_H];
            s_q <= s_nxt;
            v_q <= nxt_bits[B_V];
            n_q <= nxt_bits[B_N];
            z_q <= nxt_bits[B_Z];
            c_q <= nxt_bits[B_C];
        end
    end

    assign h_o = h_q;
    assign s_o = s_q;
    assign v_o = v_q;
    assign n_o = n_q;
    assign z_o = z_q;
    assign c_o = c_q;

    AST_CARRY_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(upd_mask_i[B_C])) |-> (c_o == $past(c_o))); // R2
    AST_CARRY_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        upd_mask_i[B_C] |=> (c_o == $past(alu_flags_i[B_C]))); // R2
    AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(upd_mask_i[B_N] || upd_mask_i[B_V]) |=> $stable(s_o)); // R4

endmodule

// File: rtl/sreg_tbit.sv
module sreg_tbit #(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bst_i,
    input  logic [SEL_W-1:0]  bit_sel_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic              t_o,
    output logic [DATA_W-1:0] bld_data_o
);

    logic t_q;
    logic picked;

    always_comb begin
        picked = 1'b0;
        for (int k = 0; k < DATA_W; k++) begin
            if (bit_sel_i == SEL_W'(k)) picked = opnd_i[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        t_q <= 1'b0;
        else if (bst_i) t_q <= picked;
    end

    for (genvar k = 0; k < DATA_W; k++) begin : g_insert
        assign bld_data_o[k] = (bit_sel_i == SEL_W'(k)) ? t_q : opnd_i[k];
    end

    assign t_o = t_q;

    AST_BST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        bst_i |=> (t_o == $past(opnd_i[bit_sel_i]))); // R5
    AST_T_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bst_i |=> $stable(t_o)); // R5
    AST_BLD_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        $countones(bld_data_o ^ opnd_i) <= 1); // R6

endmodule

// File: rtl/sreg_gie_ctrl.sv
module sreg_gie_ctrl
    import sreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic irq_entry_i,
    input  logic reti_i,
    input  logic sei_i,
    input  logic cli_i,
    output logic gie_o
);

    gie_act_e act;
    logic     gie_q;

    assign act = gie_decide(irq_entry_i, cli_i, sei_i, reti_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q <= 1'b0;
        end else begin
            unique case (act)
                GIE_ENTRY: gie_q <= 1'b0;
                GIE_CLEAR: gie_q <= 1'b0;
                GIE_SET:   gie_q <= 1'b1;
                default:   gie_q <= gie_q;
            endcase
        end
    end

    assign gie_o = gie_q;

    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        irq_entry_i |=> !gie_o); // R7
    AST_RETI_SETS: assert property (@(posedge clk) disable iff (rst)
        (reti_i && !irq_entry_i && !cli_i) |=> gie_o); // R8
    AST_CLI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cli_i |=> !gie_o); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(irq_entry_i || reti_i || sei_i || cli_i) |=> $stable(gie_o)); // R10

endmodule

// File: rtl/sreg_irq_gate.sv
module sreg_irq_gate #(
    parameter int NSRC = 4
) (
    input  logic            gie_i,
    input  logic [NSRC-1:0] irq_req_i,
    input  logic [NSRC-1:0] irq_en_i,
    output logic            irq_take_o
);

    logic [NSRC-1:0] live;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign live[k] = irq_req_i[k] & irq_en_i[k];
    end

    assign irq_take_o = gie_i & (|live);

endmodule

// File: rtl/sreg_unit.sv
module sreg_unit
    import sreg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NSRC   = 4,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SW-1:0]     alu_flags_i,
    input  logic [SW-1:0]     upd_mask_i,
    input  logic              bst_i,
    input  logic              bld_i,
    input  logic [SEL_W-1:0]  bit_sel_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] bld_data_o,
    input  logic              irq_entry_i,
    input  logic              reti_i,
    input  logic              sei_i,
    input  logic              cli_i,
    input  logic [NSRC-1:0]   irq_req_i,
    input  logic [NSRC-1:0]   irq_en_i,
    output logic              irq_take_o,
    output logic [SW-1:0]     sreg_o,
    output logic              gie_o,
    output logic              tflag_o
);

    sreg_t word;
    logic  f_h, f_s, f_v, f_n, f_z, f_c;
    logic  t_bit;
    logic  gie;

    sreg_flag_merge u_flags (
        .clk         (clk),
        .rst         (rst),
        .alu_flags_i (alu_flags_i),
        .upd_mask_i  (upd_mask_i),
        .h_o         (f_h),
        .s_o         (f_s),
        .v_o         (f_v),
        .n_o         (f_n),
        .z_o         (f_z),
        .c_o         (f_c)
    );

    sreg_tbit #(.DATA_W(DATA_W)) u_tbit (
        .clk        (clk),
        .rst        (rst),
        .bst_i      (bst_i),
        .bit_sel_i  (bit_sel_i),
        .opnd_i     (opnd_i),
        .t_o        (t_bit),
        .bld_data_o (bld_data_o)
    );

    sreg_gie_ctrl u_gie (
        .clk         (clk),
        .rst         (rst),
        .irq_entry_i (irq_entry_i),
        .reti_i      (reti_i),
        .sei_i       (sei_i),
        .cli_i       (cli_i),
        .gie_o       (gie)
    );

    sreg_irq_gate #(.NSRC(NSRC)) u_gate (
        .gie_i      (gie),
        .irq_req_i  (irq_req_i),
        .irq_en_i   (irq_en_i),
        .irq_take_o (irq_take_o)
    );

    always_comb begin
        word.i = gie;
        word.t = t_bit;
        word.h = f_h;
        word.s = f_s;
        word.v = f_v;
        word.n = f_n;
        word.z = f_z;
        word.c = f_c;
    end

    assign sreg_o  = word;
    assign gie_o   = gie;
    assign tflag_o = t_bit;

    AST_SIGN_IS_XOR: assert property (@(posedge clk) disable iff (rst)
        sreg_o[B_S] == (sreg_o[B_N] ^ sreg_o[B_V])); // R4
    AST_GATED_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !gie_o |-> !irq_take_o); // R11
    AST_T_IGNORES_ALU: assert property (@(posedge clk) disable iff (rst)
        (!bst_i && upd_mask_i[B_T]) |=> $stable(tflag_o)); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (sreg_o == '0)); // R1
    AST_BLD_STROBE_SANE: assert property (@(posedge clk) disable iff (rst)
        bld_i |-> (bld_data_o[bit_sel_i] == tflag_o)); // R6

endmodule

// File: tb/tb_sreg_unit.sv
module tb_sreg_unit;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] alu_flags_i, upd_mask_i, opnd_i, bld_data_o, sreg_o;
    logic       bst_i, bld_i, irq_entry_i, reti_i, sei_i, cli_i;
    logic [2:0] bit_sel_i;
    logic [3:0] irq_req_i, irq_en_i;
    logic       irq_take_o, gie_o, tflag_o;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    sreg_unit dut (
        .clk(clk), .rst(rst),
        .alu_flags_i(alu_flags_i), .upd_mask_i(upd_mask_i),
        .bst_i(bst_i), .bld_i(bld_i), .bit_sel_i(bit_sel_i), .opnd_i(opnd_i),
        .bld_data_o(bld_data_o),
        .irq_entry_i(irq_entry_i), .reti_i(reti_i), .sei_i(sei_i), .cli_i(cli_i),
        .irq_req_i(irq_req_i), .irq_en_i(irq_en_i), .irq_take_o(irq_take_o),
        .sreg_o(sreg_o), .gie_o(gie_o), .tflag_o(tflag_o)
    );

    // {mask, alu flags, expected word}, applied in order from a cleared word
    localparam logic [23:0] VEC [8] = '{
        {8'h2F, 8'h2F, 8'h2F},   // R2 all ALU flags loaded
        {8'h01, 8'h00, 8'h2E},   // R2 only C written
        {8'h08, 8'h00, 8'h36},   // R4 V cleared, S = N
        {8'hD0, 8'hFF, 8'h36},   // R3 I/T/S mask bits ignored
        {8'h04, 8'h00, 8'h22},   // R4 N cleared, S = 0
        {8'h22, 8'h00, 8'h00},   // R2 H and Z cleared
        {8'h00, 8'hFF, 8'h00},   // R2 empty mask holds
        {8'h0C, 8'h08, 8'h18}    // R4 V set, N clear, S = 1
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_flags_i = 8'h00; upd_mask_i = 8'h00;
        bst_i = 0; bld_i = 0; bit_sel_i = 3'd0; opnd_i = 8'h00;
        irq_entry_i = 0; reti_i = 0; sei_i = 0; cli_i = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic gie_evt(input logic e, input logic r, input logic s, input logic c);
        irq_entry_i = e; reti_i = r; sei_i = s; cli_i = c;
        step();
        idle();
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle();
        irq_req_i = 4'h0; irq_en_i = 4'h0;
        rst = 1;
        step(); step();
        rst = 0;
        chk("R1 word", sreg_o, 8'h00);
        chk("R1 gie/t/take", {5'd0, gie_o, tflag_o, irq_take_o}, 8'h00);

        for (int k = 0; k < 8; k++) begin
            upd_mask_i  = VEC[k][23:16];
            alu_flags_i = VEC[k][15:8];
            step();
            idle();
            chk("R2/R3/R4 table", sreg_o, VEC[k][7:0]);
        end

        // bit-store / bit-load
        bst_i = 1; bit_sel_i = 3'd5; opnd_i = 8'h20;
        step(); idle();
        chk("R5 bst sets T", {7'd0, tflag_o}, 8'h01);
        chk("R5 T in word", sreg_o, 8'h58);
        bld_i = 1; bit_sel_i = 3'd3; opnd_i = 8'h00; #1;
        chk("R6 bld insert 1", bld_data_o, 8'h08);
        idle();
        upd_mask_i = 8'hFF; alu_flags_i = 8'h00;
        step(); idle();
        chk("R3 T survives full mask", sreg_o, 8'h40);
        bst_i = 1; bit_sel_i = 3'd0; opnd_i = 8'hFE;
        step(); idle();
        chk("R5 bst clears T", {7'd0, tflag_o}, 8'h00);
        bld_i = 1; bit_sel_i = 3'd7; opnd_i = 8'hFF; #1;
        chk("R6 bld insert 0", bld_data_o, 8'h7F);
        idle();
        opnd_i = 8'hFF;
        step(); idle();
        chk("R5 T holds without bst", {7'd0, tflag_o}, 8'h00);

        // global enable
        gie_evt(0, 0, 1, 0);
        chk("R9 sei sets I", {7'd0, gie_o}, 8'h01);
        irq_req_i = 4'b0100; irq_en_i = 4'b0100; #1;
        chk("R11 take when enabled", {7'd0, irq_take_o}, 8'h01);
        irq_en_i = 4'b1011; #1;
        chk("R11 no matching enable", {7'd0, irq_take_o}, 8'h00);
        upd_mask_i = 8'h80; alu_flags_i = 8'h00;
        step(); idle();
        chk("R3 I ignores ALU mask", {7'd0, gie_o}, 8'h01);
        gie_evt(1, 0, 0, 0);
        chk("R7 entry clears I", {7'd0, gie_o}, 8'h00);
        irq_en_i = 4'hF; irq_req_i = 4'hF; #1;
        chk("R11 gated while I off", {7'd0, irq_take_o}, 8'h00);
        gie_evt(0, 1, 0, 0);
        chk("R8 reti sets I", {7'd0, gie_o}, 8'h01);
        gie_evt(1, 0, 1, 0);
        chk("R10 entry beats sei", {7'd0, gie_o}, 8'h00);
        gie_evt(0, 1, 0, 0);
        gie_evt(1, 1, 0, 0);
        chk("R10 entry beats reti", {7'd0, gie_o}, 8'h00);
        gie_evt(0, 0, 1, 0);
        gie_evt(0, 0, 0, 1);
        chk("R9 cli clears I", {7'd0, gie_o}, 8'h00);
        gie_evt(0, 0, 1, 1);
        chk("R9 cli beats sei", {7'd0, gie_o}, 8'h00);

        // mid-run reset
        gie_evt(0, 0, 1, 0);
        upd_mask_i = 8'h2F; alu_flags_i = 8'h2F;
        step(); idle();
        rst = 1;
        step();
        rst = 0;
        chk("R1 reset mid-run", sreg_o, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule